// File: doc/BRIEF.md
# GPIO bank controller

A register-mapped controller for one bank of 32 general-purpose pins, accessed over a simple word-wide bus. The bus has an address, a write enable, write data, and read data that is returned in the same cycle. Software sets the direction of each pin. It drives outputs only through a write-only set register and a write-only clear register. It reads back the synchronized level of every pin. It can detect rising edges, falling edges or both on each pin, and each detected edge is latched in a sticky, write-1-to-clear status register. The interrupt output is the OR of all status bits.

Each pin has a 2-bit function code. The code hands the pin either to the GPIO logic or to one of three alternate-function peripherals. When a peripheral owns a pin, that peripheral's output and output-enable drive the pin, and the pin level is routed back to that peripheral's input. A parameter marks a set of dedicated pins. These pins come out of reset owned by alternate function 0 and need code 01 to act as GPIO. On these pins the direction bit is inverted.

Top module: `gpio_bank`

## Requirements
- R1: After reset, the following registers read 0: direction, rise enable, fall enable, status, and both select registers. `irq_o` is 0. Normal pins are inputs with `pin_oe_o`=0 and `pin_o`=0. Dedicated pins (default mask 0xF000_0000) drive alternate function 0's output and output-enable.
- R2: Word addresses: 2 = set, 3 = clear. A 1 bit written to the set register drives that pin's GPIO output high. A 1 bit written to the clear register drives it low. Bits written as 0 leave the output unchanged. Both registers read back 0.
- R3: Address 1 = direction. In GPIO mode a normal pin drives (`pin_oe_o`=1) when its direction bit is 1. A dedicated pin in GPIO mode drives when its direction bit is 0.
- R4: Address 0 = level. It returns the pin inputs after a two-flop synchronizer, so a change on `pin_i` is visible after two clock edges, whatever the pin's direction or function.
- R5: Address 4 = rise enable, address 5 = fall enable. Each selects its edge type per pin, and both may be set on the same pin. An enabled edge sets the pin's status bit (address 6) three clock edges after `pin_i` changes. Disabled edges set nothing.
- R6: Status bits are sticky. Writing a 1 to a status bit clears it, and writing a 0 leaves it unchanged. An enabled edge that arrives in the same cycle as the clear leaves the bit set.
- R7: Normal pins: code 00 selects GPIO, and codes 01/10/11 select alternate functions 0/1/2. The selected function drives `pin_o` and `pin_oe_o`. `alt_in_o[k][p]` equals `pin_i[p]` only while function k owns pin p, and is 0 otherwise.
- R8: Dedicated pins: code 00 selects alternate function 0, code 01 selects GPIO, and codes 10/11 select alternate functions 1/2.
- R9: `irq_o` is 1 exactly when at least one status bit is set.
- R10: Address 7 holds the codes of pins 0–15 and address 8 holds pins 16–31. Pin p's code sits at bits [2(p mod 16)+1 : 2(p mod 16)]. Both registers read back what was written. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 4 | Register word address |
| we_i | input | 1 | Write enable |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i`, same cycle |
| pin_i | input | 32 | Pin input levels |
| pin_o | output | 32 | Pin output levels |
| pin_oe_o | output | 32 | Pin output enables |
| alt_out_i | input | 3x32 | Output value from each alternate function |
| alt_oe_i | input | 3x32 | Output enable from each alternate function |
| alt_in_o | output | 3x32 | Pin level routed to the owning alternate function |
| irq_o | output | 1 | OR of all edge status bits |

## Verification
The hardest case to reach is an edge being detected in the same cycle as a write-1-to-clear of the same status bit, because the detection lags the pin change by the synchronizer depth. The bench first sets the bit with one edge. It then toggles the pin on a falling clock edge and counts two rising edges. It then issues the clear write so that the write lands on the third edge, when the edge is detected. It checks that the bit survives, and that a later lone clear removes it. The dedicated pins are walked through every function code, checking both the swapped codes and the inverted direction sense.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int ADDR_W = 4;

  typedef enum logic [ADDR_W-1:0] {
    A_LEVEL   = 4'h0,
    A_DIR     = 4'h1,
    A_SET     = 4'h2,
    A_CLR     = 4'h3,
    A_RISE    = 4'h4,
    A_FALL    = 4'h5,
    A_STAT    = 4'h6,
    A_FSEL_LO = 4'h7,
    A_FSEL_HI = 4'h8
  } reg_addr_e;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int N = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] pin_i,
  output logic [N-1:0] level_o,
  output logic [N-1:0] rise_o,
  output logic [N-1:0] fall_o
);
  logic [N-1:0] s1_q, s2_q, dly_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q  <= '0;
      s2_q  <= '0;
      dly_q <= '0;
    end else begin
      s1_q  <= pin_i;
      s2_q  <= s1_q;
      dly_q <= s2_q;
    end
  end

  assign level_o = s2_q;
  assign rise_o  = s2_q & ~dly_q;
  assign fall_o  = ~s2_q & dly_q;
endmodule

// File: rtl/gpio_edge_stat.sv
module gpio_edge_stat #(
  parameter int N = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] rise_i,
  input  logic [N-1:0] fall_i,
  input  logic [N-1:0] rise_en_i,
  input  logic [N-1:0] fall_en_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] hit_o,
  output logic [N-1:0] stat_o
);
  logic [N-1:0] stat_q;

  assign hit_o = (rise_i & rise_en_i) | (fall_i & fall_en_i);

  // set dominates clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stat_q <= '0;
    else         stat_q <= (stat_q & ~clr_i) | hit_o;
  end

  assign stat_o = stat_q;
endmodule

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux #(
  parameter int          N        = 32,
  parameter int          FSEL_W   = 2,
  parameter int          NUM_ALT  = 3,
  parameter logic [N-1:0] DED_MASK = '0
) (
  input  logic [N-1:0][FSEL_W-1:0] fsel_i,
  input  logic [N-1:0]             gpio_out_i,
  input  logic [N-1:0]             dir_i,
  input  logic [N-1:0]             pin_i,
  input  logic [NUM_ALT-1:0][N-1:0] alt_out_i,
  input  logic [NUM_ALT-1:0][N-1:0] alt_oe_i,
  output logic [N-1:0]             pin_o,
  output logic [N-1:0]             pin_oe_o,
  output logic [NUM_ALT-1:0][N-1:0] alt_in_o
);
  for (genvar p = 0; p < N; p++) begin : g_pin
    logic              is_gpio;
    logic [FSEL_W-1:0] idx;

    // dedicated pins swap codes 00 and 01
    assign is_gpio = DED_MASK[p] ? (fsel_i[p] == FSEL_W'(1)) : (fsel_i[p] == '0);
    assign idx     = (fsel_i[p] == '0) ? '0 : fsel_i[p] - FSEL_W'(1);

    assign pin_o[p]    = is_gpio ? gpio_out_i[p] : alt_out_i[idx][p];
    assign pin_oe_o[p] = is_gpio ? (dir_i[p] ^ DED_MASK[p]) : alt_oe_i[idx][p];

    for (genvar k = 0; k < NUM_ALT; k++) begin : g_alt
      assign alt_in_o[k][p] = !is_gpio && (idx == FSEL_W'(k)) && pin_i[p];
    end
  end
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank import gpio_bank_pkg::*; #(
  parameter int             N        = 32,
  parameter int             FSEL_W   = 2,
  parameter logic [N-1:0]   DED_MASK = 32'hF000_0000,
  localparam int            NUM_ALT  = (1 << FSEL_W) - 1
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [ADDR_W-1:0]         addr_i,
  input  logic                      we_i,
  input  logic [N-1:0]              wdata_i,
  output logic [N-1:0]              rdata_o,
  input  logic [N-1:0]              pin_i,
  output logic [N-1:0]              pin_o,
  output logic [N-1:0]              pin_oe_o,
  input  logic [NUM_ALT-1:0][N-1:0] alt_out_i,
  input  logic [NUM_ALT-1:0][N-1:0] alt_oe_i,
  output logic [NUM_ALT-1:0][N-1:0] alt_in_o,
  output logic                      irq_o
);
  localparam int HALF = N / 2;

  logic [N-1:0]             dir_q, out_q, rise_en_q, fall_en_q;
  logic [N-1:0][FSEL_W-1:0] fsel_q;
  logic [N-1:0]             set_mask, clr_mask, stat_clr;
  logic [N-1:0]             level, rise, fall, edge_hit, stat_q;

  assign set_mask = (we_i && addr_i == A_SET)  ? wdata_i : '0;
  assign clr_mask = (we_i && addr_i == A_CLR)  ? wdata_i : '0;
  assign stat_clr = (we_i && addr_i == A_STAT) ? wdata_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q     <= '0;
      out_q     <= '0;
      rise_en_q <= '0;
      fall_en_q <= '0;
      fsel_q    <= '0;
    end else begin
      out_q <= (out_q | set_mask) & ~clr_mask;
      if (we_i) begin
        case (addr_i)
          A_DIR:     dir_q            <= wdata_i;
          A_RISE:    rise_en_q        <= wdata_i;
          A_FALL:    fall_en_q        <= wdata_i;
          A_FSEL_LO: fsel_q[HALF-1:0] <= wdata_i;
          A_FSEL_HI: fsel_q[N-1:HALF] <= wdata_i;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (addr_i)
      A_LEVEL:   rdata_o = level;
      A_DIR:     rdata_o = dir_q;
      A_RISE:    rdata_o = rise_en_q;
      A_FALL:    rdata_o = fall_en_q;
      A_STAT:    rdata_o = stat_q;
      A_FSEL_LO: rdata_o = fsel_q[HALF-1:0];
      A_FSEL_HI: rdata_o = fsel_q[N-1:HALF];
      default:   rdata_o = '0;
    endcase
  end

  gpio_in_sync #(.N(N)) i_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .pin_i   (pin_i),
    .level_o (level),
    .rise_o  (rise),
    .fall_o  (fall)
  );

  gpio_edge_stat #(.N(N)) i_stat (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rise_i    (rise),
    .fall_i    (fall),
    .rise_en_i (rise_en_q),
    .fall_en_i (fall_en_q),
    .clr_i     (stat_clr),
    .hit_o     (edge_hit),
    .stat_o    (stat_q)
  );

  gpio_pin_mux #(
    .N        (N),
    .FSEL_W   (FSEL_W),
    .NUM_ALT  (NUM_ALT),
    .DED_MASK (DED_MASK)
  ) i_mux (
    .fsel_i     (fsel_q),
    .gpio_out_i (out_q),
    .dir_i      (dir_q),
    .pin_i      (pin_i),
    .alt_out_i  (alt_out_i),
    .alt_oe_i   (alt_oe_i),
    .pin_o      (pin_o),
    .pin_oe_o   (pin_oe_o),
    .alt_in_o   (alt_in_o)
  );

  assign irq_o = |stat_q;
endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk import gpio_bank_pkg::*; #(
  parameter int N = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              we_i,
  input logic [N-1:0]      wdata_i,
  input logic [N-1:0]      rdata_o,
  input logic              irq_o,
  input logic [N-1:0]      out_q,
  input logic [N-1:0]      stat_q,
  input logic [N-1:0]      edge_hit
);
  logic [N-1:0] w1c;
  assign w1c = (we_i && addr_i == A_STAT) ? wdata_i : '0;

  p_set_high_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == A_SET) |=> ((out_q & $past(wdata_i)) == $past(wdata_i)));

  p_clr_low_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == A_CLR) |=> ((out_q & $past(wdata_i)) == '0));

  p_out_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && (addr_i == A_SET || addr_i == A_CLR)) |=> $stable(out_q));

  p_wo_read_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == A_SET || addr_i == A_CLR) |-> (rdata_o == '0));

  p_stat_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((($past(stat_q) & ~$past(w1c)) & ~stat_q) == '0));

  p_edge_beats_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((edge_hit & w1c) != '0) |=> ((stat_q & $past(edge_hit & w1c)) == $past(edge_hit & w1c)));

  p_irq_cause_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> ($past(edge_hit) != '0));
endmodule

bind gpio_bank gpio_bank_chk #(.N(N)) i_gpio_bank_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .addr_i   (addr_i),
  .we_i     (we_i),
  .wdata_i  (wdata_i),
  .rdata_o  (rdata_o),
  .irq_o    (irq_o),
  .out_q    (out_q),
  .stat_q   (stat_q),
  .edge_hit (edge_hit)
);

// File: tb/test_gpio_bank.sv
`timescale 1ns/1ps
module test_gpio_bank;
  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [3:0]        addr = '0;
  logic              we = 1'b0;
  logic [31:0]       wdata = '0;
  logic [31:0]       rdata;
  logic [31:0]       pin_in = '0;
  logic [31:0]       pin_out, pin_oe;
  logic [2:0][31:0]  alt_out, alt_oe, alt_in;
  logic              irq;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk;

  gpio_bank i_gpio_bank (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .addr_i    (addr),
    .we_i      (we),
    .wdata_i   (wdata),
    .rdata_o   (rdata),
    .pin_i     (pin_in),
    .pin_o     (pin_out),
    .pin_oe_o  (pin_oe),
    .alt_out_i (alt_out),
    .alt_oe_i  (alt_oe),
    .alt_in_o  (alt_in),
    .irq_o     (irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; we = 1'b0; pin_in = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic peek(input logic [3:0] a, output logic [31:0] v);
    addr = a;
    #1 v = rdata;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    do_reset();
    for (int a = 0; a < 16; a++) begin
      peek(4'(a), v);
      chk($sformatf("R1 R10 reg %0d after reset", a), v, 32'h0);
    end
    chk("R1 oe after reset", pin_oe, 32'hF000_0000);
    chk("R1 out after reset", pin_out, 32'h5000_0000);
    chk("R1 irq after reset", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_set_clr();
    logic [31:0] v;
    do_reset();
    wr(4'h1, 32'h0000_00FF);
    chk("R3 normal oe from dir", pin_oe & 32'h0FFF_FFFF, 32'h0000_00FF);
    wr(4'h2, 32'h0000_00F0);
    chk("R2 set", pin_out & 32'h0FFF_FFFF, 32'h0000_00F0);
    wr(4'h2, 32'h0000_0003);
    chk("R2 set keeps zeros", pin_out & 32'h0FFF_FFFF, 32'h0000_00F3);
    wr(4'h3, 32'h0000_0011);
    chk("R2 clear", pin_out & 32'h0FFF_FFFF, 32'h0000_00E2);
    peek(4'h2, v); chk("R2 set reads 0", v, 32'h0);
    peek(4'h3, v); chk("R2 clear reads 0", v, 32'h0);
  endtask

  task automatic t_dedicated();
    do_reset();
    pin_in = 32'h2000_0000;
    wr(4'h2, 32'h1000_0000);
    wr(4'h8, 32'h0100_0000);   // pin 28 code 01 -> GPIO
    chk("R8 R3 ded gpio oe dir0", pin_oe[31:28], 4'hF);
    chk("R8 ded gpio out", pin_out[31:28], 4'h5);
    wr(4'h1, 32'h1000_0000);
    chk("R3 ded dir1 not driving", pin_oe[31:28], 4'hE);
    wr(4'h8, 32'h0900_0000);   // pin 29 code 10 -> alt 1
    chk("R8 ded code10 out", pin_out[31:28], 4'h7);
    chk("R8 ded code10 oe", pin_oe[31:28], 4'hC);
    chk("R8 R7 alt1 in", alt_in[1], 32'h2000_0000);
    chk("R7 alt0 in gated", alt_in[0], 32'h0);
    wr(4'h8, 32'h0C00_0000);   // pin 29 code 11 -> alt 2
    chk("R8 ded code11 alt2 in", alt_in[2], 32'h2000_0000);
  endtask

  task automatic t_alt_normal();
    logic [31:0] v;
    do_reset();
    pin_in = 32'h0000_000F;
    wr(4'h7, 32'h0000_0039);   // pin0 01, pin1 10, pin2 11, pin3 00
    chk("R7 alt outs", pin_out[3:0], 4'h7);
    chk("R7 alt oes", pin_oe[3:0], 4'h3);
    chk("R7 alt0 in", alt_in[0] & 32'hF, 32'h1);
    chk("R7 alt1 in", alt_in[1] & 32'hF, 32'h2);
    chk("R7 alt2 in", alt_in[2] & 32'hF, 32'h4);
    wr(4'h8, 32'h0000_0002);   // pin16 code 10
    chk("R10 hi half pin16 oe", {31'b0, pin_oe[16]}, 32'h1);
    peek(4'h7, v); chk("R10 lo readback", v, 32'h0000_0039);
    peek(4'h8, v); chk("R10 hi readback", v, 32'h0000_0002);
    peek(4'hC, v); chk("R10 unmapped reads 0", v, 32'h0);
  endtask

  task automatic t_level();
    logic [31:0] v;
    do_reset();
    pin_in = 32'h1234_5678;
    @(negedge clk);
    peek(4'h0, v); chk("R4 level after 1 edge", v, 32'h0);
    @(negedge clk);
    peek(4'h0, v); chk("R4 level after 2 edges", v, 32'h1234_5678);
    wr(4'h1, 32'hFFFF_FFFF);
    pin_in = 32'hCAFE_0001;
    repeat (2) @(negedge clk);
    peek(4'h0, v); chk("R4 level on outputs", v, 32'hCAFE_0001);
  endtask

  task automatic t_edges();
    logic [31:0] v;
    do_reset();
    wr(4'h4, 32'h0000_0005);
    wr(4'h5, 32'h0000_0006);
    repeat (3) @(negedge clk);
    pin_in = 32'h0000_000F;
    repeat (2) @(negedge clk);
    peek(4'h6, v); chk("R5 no status before 3 edges", v, 32'h0);
    chk("R9 irq low before", {31'b0, irq}, 32'h0);
    @(negedge clk);
    peek(4'h6, v); chk("R5 rise status", v, 32'h0000_0005);
    chk("R9 irq high", {31'b0, irq}, 32'h1);
    wr(4'h6, 32'h0000_0005);
    peek(4'h6, v); chk("R6 w1c", v, 32'h0);
    chk("R9 irq low after clear", {31'b0, irq}, 32'h0);
    pin_in = 32'h0;
    repeat (3) @(negedge clk);
    peek(4'h6, v); chk("R5 fall status", v, 32'h0000_0006);
  endtask

  task automatic t_race();
    logic [31:0] v;
    do_reset();
    wr(4'h4, 32'h1);
    wr(4'h5, 32'h1);
    pin_in = 32'h1;
    repeat (4) @(negedge clk);
    repeat (10) @(negedge clk);
    peek(4'h6, v); chk("R6 sticky", v, 32'h1);
    wr(4'h6, 32'h2);
    peek(4'h6, v); chk("R6 zero bits keep", v, 32'h1);
    pin_in = 32'h0;
    repeat (2) @(negedge clk);
    addr = 4'h6; wdata = 32'h1; we = 1'b1;   // lands with the detected fall
    @(negedge clk);
    we = 1'b0;
    peek(4'h6, v); chk("R6 edge beats clear", v, 32'h1);
    wr(4'h6, 32'h1);
    peek(4'h6, v); chk("R6 lone clear", v, 32'h0);
  endtask

  initial begin
    alt_out[0] = 32'h5555_5555; alt_oe[0] = 32'hFFFF_FFFF;
    alt_out[1] = 32'hAAAA_AAAA; alt_oe[1] = 32'h0F0F_0F0F;
    alt_out[2] = 32'h0000_FFFF; alt_oe[2] = 32'hFFFF_0000;
    t_reset();
    t_set_clr();
    t_dedicated();
    t_alt_normal();
    t_level();
    t_edges();
    t_race();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule